// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Output Driver Controller

This block is a serial slave that sets eight output-enable lines and reports a sticky fault status for each channel. A host lowers the chip-select line, clocks command bits in and status bits out, then raises chip-select. On that rising edge the command byte becomes the new channel state and the stored status is wiped. Fault signals from the power stages are stored per channel until the next end of a frame, so a short fault is never lost between two reads.

The slave reads its serial input on the falling serial-clock edge and updates its serial output on the rising edge. Every serial line is first resynchronised into the faster system clock, and all edges are detected from the synchronised copies. Because status leaves the shift register while command bits enter it, several devices can share one chip-select, with one device's output feeding the next device's input. The lowest four channels can also be switched on directly by active-high inputs, which suits pulse-width modulation. A common active-low reset turns every channel off. A single flag output shows that at least one channel has a stored fault.

Top module: `spi_octal_driver`

## Requirements
- R1: While chip-select is low, the serial input is sampled on each falling serial-clock edge, most significant bit first. Command bit k controls channel k+1, so bit 7 controls channel 8 and bit 0 controls channel 1.
- R2: When chip-select falls, the stored status is loaded in parallel into the shift register, and the serial output enable goes high. The serial output then shows status bit 7 (channel 8) and moves to the next bit on each rising serial-clock edge.
- R3: Once eight bits have been clocked in, the serial output presents the received input bits in the order they arrived, which allows chaining.
- R4: The channel state changes only when chip-select rises. It then takes the last eight bits received, whatever the frame length.
- R5: While chip-select is high, the serial clock and serial input have no effect, and the serial output enable is low.
- R6: Each channel's status bit is set by its fault input and stays set until the next chip-select rising edge or reset clears it.
- R7: The fault flag is high exactly when at least one status bit is set.
- R8: Channels 1 to 4 are on when either their command bit or their direct input is high. Channels 5 to 8 follow only their command bit.
- R9: While reset is low, all channel outputs are off. Reset also clears the command bits and the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Common active-low reset; forces all channels off |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial status output, driven low while disabled |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| pwm_in | input | 4 | Direct active-high controls for channels 1 to 4 |
| fault_in | input | 8 | Per-channel fault indications, bit k for channel k+1 |
| chan_on | output | 8 | Channel enables, bit k for channel k+1 |
| fault_flag | output | 1 | High while any stored fault bit is set |

## Verification
A corrupted shift register shows up on sdo within one serial-clock period of the bit involved. It also reaches chan_on a few system cycles after chip-select rises, once the synchroniser stages have passed the edge. A status bit that is wrongly cleared or stuck is visible on fault_flag one cycle after the fault pulse, and in the first status byte read out in the next frame. Chained frames and frames whose length is not a multiple of eight are checked, because an error in the shift order only shows in the bits that come after the first eight.

// File: rtl/spi_odrv_pkg.sv
package spi_odrv_pkg;
   // Reset level of the synchronised serial lines: {cs_n, sclk, sdi}
   localparam logic [2:0] SER_IDLE = 3'b100;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

   function automatic edge_t detect_edge(input logic now, input logic prev);
      edge_t e;
      e.rise = now & ~prev;
      e.fall = ~now & prev;
      return e;
   endfunction
endpackage

// File: rtl/spi_odrv_sync.sv
module spi_odrv_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_odrv_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_odrv_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= INIT;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_odrv_shift.sv
module spi_odrv_shift
   import spi_odrv_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n_s,
   input  logic         sclk_s,
   input  logic         sdi_s,
   input  logic [N-1:0] par_in,
   output logic [N-1:0] shreg_q,
   output logic         sdo_q,
   output logic         active,
   output logic         cs_rise
);
   if (N < 2) begin : g_bad_n
      $error("spi_odrv_shift: N must be at least 2");
   end

   logic  cs_prev, sclk_prev;
   edge_t cs_e, sclk_e;
   logic  load, shift_in, shift_out;

   always_comb begin
      cs_e      = detect_edge(cs_n_s, cs_prev);
      sclk_e    = detect_edge(sclk_s, sclk_prev);
      active    = ~cs_n_s;
      load      = cs_e.fall;
      shift_in  = active & ~load & sclk_e.fall;
      shift_out = active & ~load & sclk_e.rise;
      cs_rise   = cs_e.rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b0;
         shreg_q   <= '0;
         sdo_q     <= 1'b0;
      end else begin
         cs_prev   <= cs_n_s;
         sclk_prev <= sclk_s;
         if (load) begin
            shreg_q <= par_in;
            sdo_q   <= par_in[N-1];
         end else begin
            if (shift_in)  shreg_q <= {shreg_q[N-2:0], sdi_s};
            if (shift_out) sdo_q   <= shreg_q[N-1];
         end
      end
   end

   // R5: with chip-select high the shift register is frozen
   a_r5_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(shreg_q));
endmodule

// File: rtl/spi_odrv_diag.sv
module spi_odrv_diag #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] fault_in,
   input  logic         clr,
   output logic [N-1:0] diag_q,
   output logic         any_fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   diag_q <= '0;
      else if (clr) diag_q <= '0;
      else          diag_q <= diag_q | fault_in;
   end

   assign any_fault = |diag_q;

   // R6: stored bits never drop except on a clear
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((diag_q & $past(diag_q)) == $past(diag_q)));
endmodule

// File: rtl/spi_odrv_outlatch.sv
module spi_odrv_outlatch #(
   parameter int N       = 8,
   parameter int NDIRECT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [N-1:0]       din,
   input  logic [NDIRECT-1:0] pwm_in,
   output logic [N-1:0]       chan_on
);
   if (NDIRECT > N || NDIRECT < 1) begin : g_bad_direct
      $error("spi_odrv_outlatch: NDIRECT must be in 1..N");
   end

   logic [N-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    latch_q <= '0;
      else if (load) latch_q <= din;
   end

   for (genvar i = 0; i < N; i++) begin : g_chan
      if (i < NDIRECT) begin : g_direct
         assign chan_on[i] = rst_n & (latch_q[i] | pwm_in[i]);
      end else begin : g_serial
         assign chan_on[i] = rst_n & latch_q[i];
      end
   end

   // R4: the command latch moves only on a chip-select rising edge
   a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(latch_q));
endmodule

// File: rtl/spi_octal_driver.sv
module spi_octal_driver
   import spi_odrv_pkg::*;
#(
   parameter int N           = 8,
   parameter int NDIRECT     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdi,
   output logic               sdo,
   output logic               sdo_oe,
   input  logic [NDIRECT-1:0] pwm_in,
   input  logic [N-1:0]       fault_in,
   output logic [N-1:0]       chan_on,
   output logic               fault_flag
);
   logic [2:0]   ser_s;
   logic [N-1:0] shreg, diag;
   logic         sdo_q, active, cs_rise;

   spi_odrv_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(SER_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(ser_s));

   spi_odrv_shift #(.N(N)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(ser_s[2]), .sclk_s(ser_s[1]), .sdi_s(ser_s[0]),
      .par_in(diag), .shreg_q(shreg), .sdo_q(sdo_q),
      .active(active), .cs_rise(cs_rise));

   spi_odrv_diag #(.N(N)) u_diag (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .clr(cs_rise),
      .diag_q(diag), .any_fault(fault_flag));

   spi_odrv_outlatch #(.N(N), .NDIRECT(NDIRECT)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(cs_rise), .din(shreg),
      .pwm_in(pwm_in), .chan_on(chan_on));

   assign sdo_oe = active;
   assign sdo    = active & sdo_q;

   // R7: the flag can only rise after some fault input was high
   a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag) |-> $past(fault_in != '0));
endmodule

// File: tb/spi_octal_driver_test.sv
module spi_octal_driver_test;
   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic       sdo, sdo_oe, fault_flag;
   logic [3:0] pwm_in = '0;
   logic [7:0] fault_in = '0;
   logic [7:0] chan_on;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   spi_octal_driver uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .pwm_in(pwm_in), .fault_in(fault_in),
      .chan_on(chan_on), .fault_flag(fault_flag));

   // fields: tx[27:20] fault[19:12] pwm[11:8] chan_expected[7:0]
   localparam logic [27:0] VEC [0:5] = '{
      {8'hA5, 8'h00, 4'h0, 8'hA5},
      {8'h3C, 8'h81, 4'h0, 8'h3C},
      {8'h00, 8'hFF, 4'hF, 8'h0F},
      {8'hF0, 8'h12, 4'h5, 8'hF5},
      {8'h01, 8'h40, 4'h8, 8'h09},
      {8'h80, 8'h00, 4'h2, 8'h82}};

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic cs_high();
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(H);
   endtask

   task automatic shift_bits(input int n, input logic [31:0] tx, output logic [31:0] rx);
      rx = '0;
      for (int b = n - 1; b >= 0; b--) begin
         sdi  = tx[b];
         sclk = 1'b1;
         wait_clk(H);
         rx   = {rx[30:0], sdo};
         sclk = 1'b0;
         wait_clk(H);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rx;
      wait_clk(4);
      // R9 / R5: reset state
      check("R9 chan_on at reset", chan_on, 8'h00);
      check("R5 sdo_oe at reset", sdo_oe, 1'b0);
      check("R7 flag at reset", fault_flag, 1'b0);
      rst_n = 1'b1;
      wait_clk(4);

      // Vector table
      for (int v = 0; v < 6; v++) begin
         pwm_in   = VEC[v][11:8];
         fault_in = VEC[v][19:12];
         wait_clk(3);
         fault_in = '0;
         wait_clk(3);
         check("R7 flag after fault pulse", fault_flag, VEC[v][19:12] != 8'h00);
         cs_low();
         check("R2 sdo_oe in frame", sdo_oe, 1'b1);
         shift_bits(8, {24'h0, VEC[v][27:20]}, rx);
         check("R2 R6 status byte read", rx[7:0], VEC[v][19:12]);
         cs_high();
         check("R1 R8 channel state", chan_on, VEC[v][7:0]);
         check("R6 R7 flag cleared by frame end", fault_flag, 1'b0);
         pwm_in = '0;
         wait_clk(2);
         check("R8 direct inputs removed", chan_on, VEC[v][27:20]);
      end

      // R3: chained 16-bit frame, R4 latch unchanged until CS rises
      cs_low();
      shift_bits(16, 32'h0000_5AC3, rx);
      check("R3 chained output", rx[15:0], 16'h005A);
      check("R4 latch waits for CS rise", chan_on, 8'h80);
      cs_high();
      check("R4 last byte of 16", chan_on, 8'hC3);

      // R4: 12-bit frame keeps the last 8 bits
      cs_low();
      shift_bits(12, 32'h0000_0ABC, rx);
      cs_high();
      check("R4 last 8 of 12 bits", chan_on, 8'hBC);

      // R5: clocks with CS high are ignored
      for (int k = 0; k < 8; k++) begin
         sdi = 1'b1; sclk = 1'b1; wait_clk(H);
         check("R5 sdo_oe idle", sdo_oe, 1'b0);
         sclk = 1'b0; wait_clk(H);
      end
      check("R5 latch untouched", chan_on, 8'hBC);
      cs_low();
      shift_bits(8, 32'h0000_0011, rx);
      cs_high();
      check("R5 no stray status", rx[7:0], 8'h00);
      check("R1 MSB-first mapping", chan_on, 8'h11);

      // R6: fault held through frame end is set again
      fault_in = 8'h04;
      wait_clk(3);
      cs_low();
      shift_bits(8, 32'h0000_0011, rx);
      cs_high();
      check("R6 held fault returns", fault_flag, 1'b1);
      fault_in = '0;
      cs_low();
      shift_bits(8, 32'h0000_0011, rx);
      cs_high();
      check("R6 held fault read", rx[7:0], 8'h04);
      check("R6 cleared after release", fault_flag, 1'b0);

      // R9: reset overrides direct inputs and clears state
      pwm_in = 4'hF;
      fault_in = 8'h20;
      wait_clk(2);
      fault_in = '0;
      rst_n = 1'b0;
      wait_clk(2);
      check("R9 all off in reset", chan_on, 8'h00);
      check("R9 flag cleared", fault_flag, 1'b0);
      rst_n = 1'b1;
      wait_clk(4);
      check("R9 latch cleared", chan_on, 8'h0F);
      pwm_in = '0;
      wait_clk(2);
      check("R9 latch zero", chan_on, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule